// File: doc/BRIEF.md
# Multi-Cause Reset Sequencer

This block gathers every reason the chip may need to restart and turns each of them into one ordered reset sequence for the core. Four causes are recognised: the shared reset pad pulled low from outside, a low-supply indication from an analog comparator, a watchdog expiry, and an illegal-opcode fault from the core. Whatever the cause, the block first pulls the shared reset pad low so that logic on the board is reset as well. It then releases the pad and holds the core in reset for a settling count before letting it run and fetch its reset vector.

The pad-drive phase has a programmed minimum length. A watchdog or opcode reset uses exactly that minimum. A low-supply reset keeps the pad driven for as long as the supply stays low. An external-pad reset keeps the core in reset until the outside source lets go of the pad. The settling count is long when the clock comes from a crystal or resonator and short for an RC oscillator or an external clock. Two sticky flags tell software why the last reset happened. The low-supply flag survives all later resets until software clears it, so the first failure is not lost.

All cause inputs and `pad_in` are taken to be synchronous to `clk`. The power-on input `por_n` resets the block asynchronously and starts a full sequence.

Top module: `reset_sequencer`

## Requirements
- R1: While `por_n` is low, `core_reset` and `pad_drive_low` are 1 and both flags are 0. When `por_n` rises, a full sequence runs: counted from the first falling clock edge after the release, `core_reset` stays high for PHASE_CYC + STAB cycles.
- R2: In run state, a cause is any of the following: `pad_in` low, `lv_detect` high, `wdog_expired` high or `opcode_fault` high. A cause seen at one rising edge makes `core_reset` and `pad_drive_low` high after that edge.
- R3: For a watchdog or opcode reset, `pad_drive_low` is high for exactly PHASE_CYC cycles. One release cycle follows, then the settling count. `core_reset` is high for PHASE_CYC + 1 + STAB cycles in total.
- R4: For an external-pad reset held low for H cycles, the pad is driven for PHASE_CYC cycles. `core_reset` lasts max(PHASE_CYC + 1, H) + STAB cycles, because settling starts only once `pad_in` reads high with the drive released.
- R5: For a low-supply reset with `lv_detect` high for H cycles, `pad_drive_low` lasts max(PHASE_CYC, H) cycles. `core_reset` lasts that long + 1 + STAB.
- R6: STAB is STAB_LONG (default 4096) when `osc_is_crystal` is 1, and STAB_SHORT (default 256) when it is 0.
- R7: The flags read {`flag_lv`,`flag_wd`}. A watchdog reset sets `flag_wd`. A pad or opcode reset clears `flag_wd`. `lv_detect` high sets `flag_lv` and clears `flag_wd`, and wins over a simultaneous watchdog cause. The result is 00 for a pad reset, 01 for a watchdog reset and 1x for a low-supply reset.
- R8: `flag_lv` stays 1 through later watchdog, opcode and pad resets.
- R9: A one-cycle `clr_lv_flag` or `clr_wd_flag` pulse clears the matching flag at the next edge. A set in the same cycle wins over the clear.
- R10: A cause during the settling count restarts the sequence at the pad-drive phase. A watchdog or opcode cause during the pad-drive phase is ignored: it does not change the length of the sequence or `flag_wd`.
- R11: `pad_drive_low` is never high while `core_reset` is low. `core_reset` falls at a clock edge only after a cycle in which the pad was released and read high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pad_in | input | 1 | Level read back from the shared reset pad (0 = held low) |
| pad_drive_low | output | 1 | 1 pulls the shared reset pad low |
| lv_detect | input | 1 | Low-supply indication from the comparator |
| wdog_expired | input | 1 | Watchdog timeout pulse |
| opcode_fault | input | 1 | Illegal-opcode pulse from the core |
| osc_is_crystal | input | 1 | 1 selects the long settling count |
| clr_lv_flag | input | 1 | Software clear of the low-supply flag |
| clr_wd_flag | input | 1 | Software clear of the watchdog flag |
| core_reset | output | 1 | Reset to the core, active high |
| flag_lv | output | 1 | Sticky low-supply reset flag |
| flag_wd | output | 1 | Watchdog reset flag |

## Verification
The assertions check on every cycle the properties that hold cycle by cycle. A cause in run state enters reset at the next edge. The pad is driven only while the core is in reset, and the core leaves reset only after a released, high pad. A low supply sets the low-supply flag and clears the watchdog flag, the low-supply flag stays set unless software clears it, and a watchdog cause is ignored during the drive phase. The length of each phase under each cause and hold time can only be shown by the bench's scenarios. The same holds for the choice between long and short settling counts, the restart from the settling count, and the flag values left after a chain of resets.

// File: rtl/reset_sequencer.sv
module reset_sequencer #(
  parameter int PHASE_CYC  = 6000,
  parameter int STAB_LONG  = 4096,
  parameter int STAB_SHORT = 256
) (
  input  logic clk,
  input  logic por_n,
  input  logic pad_in,
  output logic pad_drive_low,
  input  logic lv_detect,
  input  logic wdog_expired,
  input  logic opcode_fault,
  input  logic osc_is_crystal,
  input  logic clr_lv_flag,
  input  logic clr_wd_flag,
  output logic core_reset,
  output logic flag_lv,
  output logic flag_wd
);

  localparam int M1   = (PHASE_CYC > STAB_LONG) ? PHASE_CYC : STAB_LONG;
  localparam int MAXC = (M1 > STAB_SHORT) ? M1 : STAB_SHORT;
  localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);

  typedef enum logic [1:0] {S_RUN, S_PHASE, S_REL, S_STAB} st_t;

  st_t           st;
  logic [CW-1:0] cnt;

  wire any_cause  = lv_detect | ~pad_in | wdog_expired | opcode_fault;
  wire fire       = ((st == S_RUN) || (st == S_STAB)) && any_cause;
  wire phase_done = (cnt == CW'(PHASE_CYC - 1));
  wire [CW-1:0] stab_end = osc_is_crystal ? CW'(STAB_LONG - 1) : CW'(STAB_SHORT - 1);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st  <= S_PHASE;
      cnt <= '0;
    end else if (fire) begin
      st  <= S_PHASE;
      cnt <= '0;
    end else begin
      case (st)
        S_PHASE: begin
          if (!phase_done) cnt <= cnt + 1'b1;
          else if (!lv_detect) st <= S_REL;
        end
        S_REL: begin
          if (lv_detect) begin
            st  <= S_PHASE;
            cnt <= '0;
          end else if (pad_in) begin
            st  <= S_STAB;
            cnt <= '0;
          end
        end
        S_STAB: begin
          if (cnt >= stab_end) st <= S_RUN;
          else cnt <= cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flag_lv <= 1'b0;
      flag_wd <= 1'b0;
    end else begin
      if (clr_lv_flag) flag_lv <= 1'b0;
      if (clr_wd_flag) flag_wd <= 1'b0;
      if (fire && !lv_detect) flag_wd <= wdog_expired;
      if (lv_detect) begin
        flag_lv <= 1'b1;
        flag_wd <= 1'b0;
      end
    end
  end

  assign core_reset    = (st != S_RUN);
  assign pad_drive_low = (st == S_PHASE);

endmodule

// File: rtl/reset_sequencer_chk.sv
module reset_sequencer_chk (
  input logic clk,
  input logic por_n,
  input logic pad_in,
  input logic pad_drive_low,
  input logic lv_detect,
  input logic wdog_expired,
  input logic opcode_fault,
  input logic clr_lv_flag,
  input logic clr_wd_flag,
  input logic core_reset,
  input logic flag_lv,
  input logic flag_wd
);

  AST_CAUSE_ENTERS_RESET: assert property (@(posedge clk) disable iff (!por_n)
    (!core_reset && (lv_detect || !pad_in || wdog_expired || opcode_fault)) |=> (core_reset && pad_drive_low)); // R2

  AST_DRIVE_ONLY_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
    pad_drive_low |-> core_reset); // R11

  AST_CLEAN_EXIT: assert property (@(posedge clk) disable iff (!por_n)
    $fell(core_reset) |-> $past(!pad_drive_low && pad_in)); // R11

  AST_LV_SETS_FLAGS: assert property (@(posedge clk) disable iff (!por_n)
    lv_detect |=> (flag_lv && !flag_wd)); // R7

  AST_LV_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    (flag_lv && !clr_lv_flag) |=> flag_lv); // R8

  AST_WD_SET: assert property (@(posedge clk) disable iff (!por_n)
    (!core_reset && wdog_expired && !lv_detect) |=> flag_wd); // R7

  AST_WD_IGNORED_IN_PHASE: assert property (@(posedge clk) disable iff (!por_n)
    (pad_drive_low && !lv_detect && !clr_wd_flag) |=> $stable(flag_wd)); // R10

endmodule

bind reset_sequencer reset_sequencer_chk u_chk (.*);

// File: tb/tb_reset_sequencer.sv
`timescale 1ns/1ps
module tb_reset_sequencer;

  localparam int P  = 20;
  localparam int SS = 256;
  localparam int SL = 4096;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic ext_hold = 1'b0;
  logic lv_detect = 1'b0, wdog_expired = 1'b0, opcode_fault = 1'b0;
  logic osc_is_crystal = 1'b0, clr_lv_flag = 1'b0, clr_wd_flag = 1'b0;
  logic pad_in, pad_drive_low, core_reset, flag_lv, flag_wd;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  assign pad_in = ~(pad_drive_low | ext_hold);

  reset_sequencer #(.PHASE_CYC(P), .STAB_LONG(SL), .STAB_SHORT(SS)) dut (
    .clk(clk), .por_n(por_n), .pad_in(pad_in), .pad_drive_low(pad_drive_low),
    .lv_detect(lv_detect), .wdog_expired(wdog_expired), .opcode_fault(opcode_fault),
    .osc_is_crystal(osc_is_crystal), .clr_lv_flag(clr_lv_flag), .clr_wd_flag(clr_wd_flag),
    .core_reset(core_reset), .flag_lv(flag_lv), .flag_wd(flag_wd)
  );

  task automatic chk(input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic set_src(input int src, input logic v);
    case (src)
      0: ext_hold = v;
      1: lv_detect = v;
      2: wdog_expired = v;
      default: opcode_fault = v;
    endcase
  endtask

  task automatic measure(input int src, input int hold, output int drv, output int rst);
    drv = 0; rst = 0;
    @(negedge clk);
    set_src(src, 1'b1);
    for (int i = 1; i < 20000; i++) begin
      @(negedge clk);
      if (i == hold) set_src(src, 1'b0);
      if (!core_reset) break;
      rst++;
      if (pad_drive_low) drv++;
    end
  endtask

  task automatic count_rst(output int n);
    n = 0;
    while (core_reset && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_por;
    int n;
    repeat (3) @(negedge clk);
    chk("R1 core_reset during por", core_reset, 1);
    chk("R1 pad drive during por", pad_drive_low, 1);
    chk("R1 flags during por", {flag_lv, flag_wd}, 0);
    por_n = 1'b1;
    @(negedge clk);
    count_rst(n);
    chk("R1 sequence after por", n, P + SS);
    chk("R11 pad released in run", pad_drive_low, 0);
  endtask

  task automatic t_wdog;
    int d, r;
    measure(2, 1, d, r);
    chk("R3 watchdog drive length", d, P);
    chk("R2 R3 watchdog reset length", r, P + 1 + SS);
    chk("R7 flags after watchdog", {flag_lv, flag_wd}, 1);
    chk("R11 pad released after exit", pad_drive_low, 0);
  endtask

  task automatic t_opcode;
    int d, r;
    measure(3, 1, d, r);
    chk("R3 opcode drive length", d, P);
    chk("R3 opcode reset length", r, P + 1 + SS);
    chk("R7 flags after opcode", {flag_lv, flag_wd}, 0);
  endtask

  task automatic t_pad_short;
    int d, r;
    measure(2, 1, d, r);
    measure(0, 5, d, r);
    chk("R4 short pad drive length", d, P);
    chk("R2 R4 short pad reset length", r, P + 1 + SS);
    chk("R7 pad reset clears watchdog flag", {flag_lv, flag_wd}, 0);
  endtask

  task automatic t_pad_long;
    int d, r;
    measure(0, 50, d, r);
    chk("R4 long pad drive length", d, P);
    chk("R4 long pad reset length", r, 50 + SS);
  endtask

  task automatic t_lvd;
    int d, r;
    measure(2, 1, d, r);
    measure(1, 60, d, r);
    chk("R5 low-supply drive length", d, 60);
    chk("R5 low-supply reset length", r, 61 + SS);
    chk("R7 flags after low supply", {flag_lv, flag_wd}, 2);
  endtask

  task automatic t_sticky;
    int d, r;
    measure(2, 1, d, r);
    chk("R8 lv flag kept across watchdog", {flag_lv, flag_wd}, 3);
    measure(0, 3, d, r);
    chk("R8 lv flag kept across pad reset", {flag_lv, flag_wd}, 2);
    measure(3, 1, d, r);
    chk("R8 lv flag kept across opcode", flag_lv, 1);
  endtask

  task automatic t_clear;
    int d, r, n;
    @(negedge clk); clr_lv_flag = 1'b1;
    @(negedge clk); clr_lv_flag = 1'b0;
    chk("R9 lv flag cleared", flag_lv, 0);
    measure(2, 1, d, r);
    @(negedge clk); clr_wd_flag = 1'b1;
    @(negedge clk); clr_wd_flag = 1'b0;
    chk("R9 wd flag cleared", flag_wd, 0);
    @(negedge clk); clr_lv_flag = 1'b1; lv_detect = 1'b1;
    @(negedge clk); clr_lv_flag = 1'b0; lv_detect = 1'b0;
    chk("R9 set wins over clear", flag_lv, 1);
    count_rst(n);
    @(negedge clk); clr_lv_flag = 1'b1;
    @(negedge clk); clr_lv_flag = 1'b0;
  endtask

  task automatic t_crystal;
    int d, r;
    osc_is_crystal = 1'b1;
    measure(2, 1, d, r);
    chk("R6 long settling length", r, P + 1 + SL);
    osc_is_crystal = 1'b0;
    measure(2, 1, d, r);
    chk("R6 short settling length", r, P + 1 + SS);
  endtask

  task automatic t_restart;
    int n;
    @(negedge clk); wdog_expired = 1'b1;
    @(negedge clk); wdog_expired = 1'b0;
    repeat (P + 2) @(negedge clk);
    opcode_fault = 1'b1;
    @(negedge clk); opcode_fault = 1'b0;
    chk("R10 restart drives pad", pad_drive_low, 1);
    count_rst(n);
    chk("R10 restart full length", n, P + 1 + SS);
    chk("R10 restart flags", {flag_lv, flag_wd}, 0);
  endtask

  task automatic t_ignore;
    int n;
    @(negedge clk); opcode_fault = 1'b1;
    @(negedge clk); opcode_fault = 1'b0;
    repeat (3) @(negedge clk);
    wdog_expired = 1'b1;
    @(negedge clk); wdog_expired = 1'b0;
    count_rst(n);
    chk("R10 watchdog ignored in phase length", n, P + 1 + SS - 4);
    chk("R10 watchdog ignored in phase flag", flag_wd, 0);
  endtask

  initial begin
    t_por();
    t_wdog();
    t_opcode();
    t_pad_short();
    t_pad_long();
    t_lvd();
    t_sticky();
    t_clear();
    t_crystal();
    t_restart();
    t_ignore();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      misses++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule